// File: doc/BRIEF.md
# Feedback Divider Dynamic Ramp Controller

This block changes the feedback multiplier N of a running PLL without letting the loop drop out of lock. Instead of reprogramming the PLL from bypass, it walks the PLL through its own slowdown and dynamic-ramp sequence. It loads two fixed ramp step sizes, enters slowdown mode, writes the new N into the coefficient word, and then enables the hardware ramp. It polls a ramp-done flag from the PLL once per microsecond until the flag is seen or a poll budget runs out.

A single-cycle request carries the target N. A request for the N that is already programmed finishes at once and changes nothing. Whatever the outcome of a ramp, the block drops slowdown mode and ramp enable together. Only after that does it pulse done or error. A one-cycle microsecond tick from the surrounding logic provides all the timing. The ramp-done flag comes from the PLL's clock domain, so the block passes it through a flop synchronizer before sampling it.

Top module: `fbdiv_ramp_ctrl`

## Requirements
- R1: During and right after reset, `coeff_word` holds M (parameter INIT_M) in bits 7:0, N (INIT_N) in bits 15:8 and PL (INIT_PL) in bits 21:16, with all other bits zero. Both step fields are 0, and `slow_en`, `ramp_en`, `busy`, `done` and `err` are all 0.
- R2: A request whose N equals the current N field makes `done` pulse in the cycle after the request. `busy` stays low, and no output other than `done` changes.
- R3: A request with a different N drives `busy` and `slow_en` high in the cycle after the request. In that same cycle `step_a` becomes 0x2B and `step_b` becomes 0x0B.
- R4: The new N appears in bits 15:8 in the cycle after the second microsecond tick seen while slowdown is on. `ramp_en` rises in the cycle after the second tick seen after that write. The M and PL fields never change.
- R5: While the ramp is enabled, the synchronized ramp-done flag is sampled on each microsecond tick. If the flag is seen on a tick, the ramp counts as successful.
- R6: `slow_en` and `ramp_en` fall in the same cycle once the outcome is decided. `done` or `err` pulses in the following cycle, with `busy` low in that cycle.
- R7: If 500 ticks pass with the ramp enabled and the ramp-done flag is never seen, `err` pulses instead of `done`. The pulse follows the exit from slowdown mode, and the new N stays programmed.
- R8: Requests that arrive while `busy` is high are ignored. They do not change the target and do not produce any extra completion.
- R9: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| req_valid | input | 1 | Request strobe |
| req_ndiv | input | 8 | Requested feedback multiplier N |
| ramp_done_async | input | 1 | Ramp-done flag from the PLL, not yet synchronized |
| coeff_word | output | 32 | Coefficient word: M 7:0, N 15:8, PL 21:16 |
| step_a | output | 8 | First ramp step-size field |
| step_b | output | 8 | Second ramp step-size field |
| slow_en | output | 1 | Slowdown-using-PLL mode enable |
| ramp_en | output | 1 | Dynamic ramp enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on ramp timeout |

## Verification
An unchanged-N request must pulse `done` exactly one cycle after the request. The scoreboard stores the request cycle and compares it against the cycle in which the pulse appears. For a real ramp, the milestones are counted in microsecond ticks rather than clock cycles: two ticks before N is written, two more before the ramp is enabled, and at most 500 while polling. The monitor counts ticks in each phase as they happen. When `done` or `err` appears, it checks that the two control bits were high two cycles earlier and low one cycle earlier, so the exit comes exactly one cycle before the report.

// File: rtl/fbdiv_ramp_pkg.sv
package fbdiv_ramp_pkg;
    parameter int M_W     = 8;
    parameter int NDIV_W  = 8;
    parameter int PL_W    = 6;
    parameter int COEFF_W = 32;
    parameter int STEP_W  = 8;
    localparam int FIELD_W = M_W + NDIV_W + PL_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SLOW,
        S_NSET,
        S_POLL,
        S_EXIT
    } ramp_state_e;

    typedef struct packed {
        ramp_state_e        state;
        logic [NDIV_W-1:0]  ndiv;
        logic [NDIV_W-1:0]  target;
        logic [STEP_W-1:0]  step_a;
        logic [STEP_W-1:0]  step_b;
        logic               slow;
        logic               ramp;
        logic               ok;
        logic               done;
        logic               err;
    } ramp_regs_t;
endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_in};
    end

    assign d_out = sh_q[STAGES-1];
endmodule

// File: rtl/ramp_tick_cnt.sv
module ramp_tick_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    logic [CW-1:0] cnt_d, cnt_q;

    assign last = step && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || last) cnt_d = '0;
        else if (step)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fbdiv_ramp_ctrl.sv
module fbdiv_ramp_ctrl
    import fbdiv_ramp_pkg::*;
#(
    parameter logic [STEP_W-1:0] STEP_A       = 8'h2B,
    parameter logic [STEP_W-1:0] STEP_B       = 8'h0B,
    parameter int                SETTLE_TICKS = 2,
    parameter int                MAX_POLLS    = 500,
    parameter int                SYNC_STAGES  = 2,
    parameter logic [M_W-1:0]    INIT_M       = 8'd1,
    parameter logic [NDIV_W-1:0] INIT_N       = 8'd40,
    parameter logic [PL_W-1:0]   INIT_PL      = 6'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_tick,
    input  logic               req_valid,
    input  logic [NDIV_W-1:0]  req_ndiv,
    input  logic               ramp_done_async,
    output logic [COEFF_W-1:0] coeff_word,
    output logic [STEP_W-1:0]  step_a,
    output logic [STEP_W-1:0]  step_b,
    output logic               slow_en,
    output logic               ramp_en,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam int PAD_W = COEFF_W - FIELD_W;

    ramp_regs_t st_d, st_q;
    logic       done_s;
    logic       in_settle, settle_last;
    logic       in_poll, poll_last;

    ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ramp_done_async),
        .d_out (done_s)
    );

    assign in_settle = (st_q.state == S_SLOW) || (st_q.state == S_NSET);
    assign in_poll   = (st_q.state == S_POLL);

    ramp_tick_cnt #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_settle),
        .step  (us_tick && in_settle),
        .last  (settle_last)
    );

    ramp_tick_cnt #(.LIMIT(MAX_POLLS)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_poll),
        .step  (us_tick && in_poll),
        .last  (poll_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        case (st_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_ndiv == st_q.ndiv) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.target = req_ndiv;
                        st_d.step_a = STEP_A;
                        st_d.step_b = STEP_B;
                        st_d.slow   = 1'b1;
                        st_d.state  = S_SLOW;
                    end
                end
            end
            S_SLOW: begin
                if (settle_last) begin
                    st_d.ndiv  = st_q.target;
                    st_d.state = S_NSET;
                end
            end
            S_NSET: begin
                if (settle_last) begin
                    st_d.ramp  = 1'b1;
                    st_d.state = S_POLL;
                end
            end
            S_POLL: begin
                if (us_tick && done_s) begin
                    st_d.ok    = 1'b1;
                    st_d.slow  = 1'b0;
                    st_d.ramp  = 1'b0;
                    st_d.state = S_EXIT;
                end else if (poll_last) begin
                    st_d.ok    = 1'b0;
                    st_d.slow  = 1'b0;
                    st_d.ramp  = 1'b0;
                    st_d.state = S_EXIT;
                end
            end
            S_EXIT: begin
                st_d.done  = st_q.ok;
                st_d.err   = !st_q.ok;
                st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.state  <= S_IDLE;
            st_q.ndiv   <= INIT_N;
            st_q.target <= INIT_N;
        end else begin
            st_q <= st_d;
        end
    end

    assign coeff_word = {{PAD_W{1'b0}}, INIT_PL, st_q.ndiv, INIT_M};
    assign step_a     = st_q.step_a;
    assign step_b     = st_q.step_b;
    assign slow_en    = st_q.slow;
    assign ramp_en    = st_q.ramp;
    assign busy       = (st_q.state != S_IDLE);
    assign done       = st_q.done;
    assign err        = st_q.err;
endmodule

// File: rtl/fbdiv_ramp_chk.sv
module fbdiv_ramp_chk
    import fbdiv_ramp_pkg::*;
#(
    parameter logic [STEP_W-1:0] STEP_A = 8'h2B,
    parameter logic [STEP_W-1:0] STEP_B = 8'h0B
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STEP_W-1:0] step_a,
    input logic [STEP_W-1:0] step_b,
    input logic              slow_en,
    input logic              ramp_en,
    input logic              busy,
    input logic              done,
    input logic              err
);
    a_r3_steps_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        slow_en |-> (step_a == STEP_A && step_b == STEP_B));

    a_r4_ramp_inside_slow: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en |-> slow_en);

    a_r6_exit_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_en) |-> $fell(ramp_en));

    a_r6_report_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_en) |=> (done || err));

    a_r6_idle_at_report: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (!busy && !slow_en));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind fbdiv_ramp_ctrl fbdiv_ramp_chk #(
    .STEP_A (STEP_A),
    .STEP_B (STEP_B)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_a  (step_a),
    .step_b  (step_b),
    .slow_en (slow_en),
    .ramp_en (ramp_en),
    .busy    (busy),
    .done    (done),
    .err     (err)
);

// File: tb/sim_fbdiv_ramp_ctrl.sv
module sim_fbdiv_ramp_ctrl;
    localparam int TICK_DIV = 10;
    localparam int INIT_N   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_ndiv = '0;
    logic        ramp_done_async = 1'b0;
    logic [31:0] coeff_word;
    logic [7:0]  step_a, step_b;
    logic        slow_en, ramp_en, busy, done, err;

    fbdiv_ramp_ctrl u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .us_tick         (us_tick),
        .req_valid       (req_valid),
        .req_ndiv        (req_ndiv),
        .ramp_done_async (ramp_done_async),
        .coeff_word      (coeff_word),
        .step_a          (step_a),
        .step_b          (step_b),
        .slow_en         (slow_en),
        .ramp_en         (ramp_en),
        .busy            (busy),
        .done            (done),
        .err             (err)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit is_err;
        int n;
        bit ramped;
        int cyc;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int done_delay = 5;
    int pre_n = 0, pre_r = 0, poll_t = 0;
    int old_n = INIT_N;
    bit p1_slow = 0, p1_ramp = 0, p2_slow = 0, p2_ramp = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Microsecond tick source and a PLL ramp model
    initial begin
        int div = 0;
        int rt = 0;
        forever begin
            @(posedge clk);
            #1;
            us_tick = (div == TICK_DIV - 1);
            div = (div == TICK_DIV - 1) ? 0 : div + 1;
            if (!ramp_en) begin
                ramp_done_async = 1'b0;
                rt = 0;
            end else begin
                if (us_tick) rt++;
                if (rt >= done_delay) ramp_done_async = 1'b1;
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (us_tick) begin
                if (ramp_en) poll_t++;
                else if (slow_en && int'(coeff_word[15:8]) == old_n) pre_n++;
                else if (slow_en) pre_r++;
            end
            if (done || err) begin
                if (q.size() == 0) begin
                    chk(0, "R8", "completion with nothing pending", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(err == e.is_err, "R7", "err vs done kind", int'(err), int'(e.is_err));
                    chk(!(done && err), "R9", "done and err together", int'(done && err), 0);
                    chk(int'(coeff_word[15:8]) == e.n, "R4", "N field at completion",
                        int'(coeff_word[15:8]), e.n);
                    chk(coeff_word[7:0] == 8'd1 && coeff_word[21:16] == 6'd1 &&
                        coeff_word[31:22] == '0, "R4", "M/PL fields",
                        int'(coeff_word & 32'hFFFF_00FF), 32'h0001_0001);
                    chk(!busy, "R6", "busy at report", int'(busy), 0);
                    chk(!slow_en && !ramp_en, "R6", "control bits at report",
                        int'({slow_en, ramp_en}), 0);
                    if (e.ramped) begin
                        chk(!p1_slow && !p1_ramp, "R6", "bits cleared one cycle before report",
                            int'({p1_slow, p1_ramp}), 0);
                        chk(p2_slow && p2_ramp, "R6", "bits both set two cycles before report",
                            int'({p2_slow, p2_ramp}), 3);
                        chk(pre_n == 2, "R4", "ticks before N write", pre_n, 2);
                        chk(pre_r == 2, "R4", "ticks before ramp enable", pre_r, 2);
                        if (e.is_err)
                            chk(poll_t == 500, "R7", "polls before timeout", poll_t, 500);
                        else
                            chk(poll_t >= 1 && poll_t < 500, "R5", "polls before success", poll_t, 1);
                    end else begin
                        chk(cyc == e.cyc, "R2", "immediate done cycle", cyc, e.cyc);
                    end
                end
            end
            p2_slow = p1_slow; p2_ramp = p1_ramp;
            p1_slow = slow_en; p1_ramp = ramp_en;
        end
    end

    task automatic do_req(input int n, input bit exp_err, input bit ramped);
        exp_t e;
        @(posedge clk);
        #2;
        req_valid = 1'b1;
        req_ndiv  = 8'(n);
        old_n = int'(coeff_word[15:8]);
        pre_n = 0; pre_r = 0; poll_t = 0;
        e.is_err = exp_err; e.n = n; e.ramped = ramped; e.cyc = cyc + 1;
        q.push_back(e);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        @(negedge clk);
        if (ramped) begin
            chk(busy && slow_en, "R3", "busy and slowdown after request",
                int'({busy, slow_en}), 3);
            chk(step_a == 8'h2B, "R3", "step A", int'(step_a), 8'h2B);
            chk(step_b == 8'h0B, "R3", "step B", int'(step_b), 8'h0B);
            chk(!ramp_en, "R4", "ramp not yet enabled", int'(ramp_en), 0);
        end else begin
            chk(!busy && !slow_en, "R2", "no sequence for same N", int'({busy, slow_en}), 0);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(coeff_word == 32'h0001_2801, "R1", "coeff in reset", int'(coeff_word), 32'h0001_2801);
        chk(!busy && !done && !err && !slow_en && !ramp_en, "R1", "flags in reset",
            int'({busy, done, err, slow_en, ramp_en}), 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(coeff_word == 32'h0001_2801, "R1", "coeff after reset", int'(coeff_word), 32'h0001_2801);
        chk(step_a == 0 && step_b == 0, "R1", "steps after reset", int'({step_a, step_b}), 0);

        // Same N as programmed: immediate completion, nothing touched
        do_req(INIT_N, 0, 0);
        drain();
        chk(step_a == 0 && step_b == 0 && coeff_word == 32'h0001_2801, "R2",
            "outputs untouched", int'(coeff_word), 32'h0001_2801);

        // Ramp up, ramp down
        done_delay = 5;
        do_req(60, 0, 1);
        drain();
        done_delay = 1;
        do_req(30, 0, 1);
        drain();

        // Timeout path
        done_delay = 1000000;
        do_req(90, 1, 1);
        drain();
        chk(coeff_word[15:8] == 8'd90, "R7", "N kept after timeout", int'(coeff_word[15:8]), 90);

        // Request ignored while busy
        done_delay = 3;
        do_req(100, 0, 1);
        repeat (15) @(negedge clk);
        #1;
        req_valid = 1'b1;
        req_ndiv  = 8'd77;
        @(negedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy && slow_en, "R8", "sequence continues after stray request",
            int'({busy, slow_en}), 3);
        drain();
        chk(coeff_word[15:8] == 8'd100, "R8", "target unchanged by stray request",
            int'(coeff_word[15:8]), 100);

        // Same N again after a ramp, then a ramp with done already waiting
        do_req(100, 0, 0);
        drain();
        done_delay = 0;
        do_req(8, 0, 1);
        drain();
        chk(q.size() == 0, "R9", "no pending completions", q.size(), 0);
        summary();
    end

    initial begin
        while (cyc < 100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end
endmodule